// File: doc/BRIEF.md
# Audio Channel FIFO with Watermarks

This block is one channel of sample buffering between a system bus and an audio codec. It stores 32-bit sample words in a 512-entry first-in first-out store. A parameter selects the flavour at elaboration. In the playback flavour the bus side writes and the codec side reads. In the capture flavour the codec side writes and the bus side reads. The consuming side always sees the oldest stored word on its read-data port, so no extra read cycle is needed.

Four level flags are updated every cycle: real-full, real-empty, almost-full and almost-empty. The two almost flags compare the occupancy against thresholds held in one packed watermark register. A push that arrives while the store is full is dropped and raises a one-cycle overflow event. Both raw pointers are exposed in one status word, so software can work out the fill level or the free space itself. A synchronous clear input empties the store.

Top module: `audio_chan_fifo`

## Requirements
- R1: After reset the store is empty, both pointers are 0, and the watermark register reads 0x000001FF (almost-empty threshold 0, almost-full threshold 511). The status nibble therefore reads 4'b1010.
- R2: Words leave in the order they entered. While the store is not empty, the consumer's read-data port shows the oldest stored word. A push and a pop in the same cycle both take effect.
- R3: A push while the occupancy is 512 is dropped even if a pop happens in the same cycle, and the stored words stay intact. In that case the overflow output is 1 for exactly the following cycle and is 0 otherwise.
- R4: A pop while the store is empty has no effect on the pointers, the flags or later data.
- R5: The status nibble has real-full at bit 0, real-empty at bit 1, almost-full at bit 2 and almost-empty at bit 3. Real-full means occupancy 512 and real-empty means occupancy 0. All flags reflect the state after the most recent clock edge.
- R6: Almost-full is 1 when occupancy >= the almost-full threshold. Almost-empty is 1 when occupancy <= the almost-empty threshold.
- R7: A watermark write loads the almost-empty threshold from bits 24:16 and the almost-full threshold from bits 8:0. The new thresholds take effect in the next cycle. All other bits read back as 0.
- R8: The pointer word holds the read index (0 to 511) in bits 25:16 and the write index in bits 9:0. Every other bit is 0. Each index advances by one, modulo 512, for each accepted pop or push. When the store is not full, free space equals 512 - wr + rd if wr >= rd, and rd - wr otherwise.
- R9: A clear that is high at a clock edge leaves the store empty with both pointers at 0 from the next cycle. It overrides any push or pop in that cycle and suppresses overflow.
- R10: In the playback flavour, the codec-side write port and the bus-side read enable are ignored, and bus read data is 0. In the capture flavour, the bus-side write port and the codec-side read enable are ignored, and codec read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clr | input | 1 | Synchronous clear of the store |
| wm_we | input | 1 | Watermark register write strobe |
| wm_wdata | input | 32 | Watermark write value |
| wm_rdata | output | 32 | Watermark register read-back |
| bus_wr_en | input | 1 | Bus-side push (playback flavour) |
| bus_wr_data | input | 32 | Bus-side push data |
| bus_rd_en | input | 1 | Bus-side pop (capture flavour) |
| bus_rd_data | output | 32 | Oldest word, bus side (capture flavour) |
| cdc_wr_en | input | 1 | Codec-side push (capture flavour) |
| cdc_wr_data | input | 32 | Codec-side push data |
| cdc_rd_en | input | 1 | Codec-side pop (playback flavour) |
| cdc_rd_data | output | 32 | Oldest word, codec side (playback flavour) |
| fifo_stat | output | 4 | Status nibble: full, empty, almost-full, almost-empty |
| ovf_evt | output | 1 | One-cycle overflow event |
| ptr_word | output | 32 | Read index in bits 25:16, write index in bits 9:0 |

## Verification
The hardest states to reach are the overflow edge and the clear at full. Both need the store filled to exactly 512 words, and then a push, or a push together with a pop, or a clear, in the very next cycle. The stimulus fills the store with over five hundred consecutive pushes of distinct data. It then pushes again, with and without a pop in the same cycle, and drains the whole store, which also forces both indices past the wrap point. A behavioural queue model runs alongside two instances, one of each flavour, fed the same traffic on their own producer and consumer ports. Changing junk is driven on the ports each flavour must ignore.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

   // status nibble bit order (consumed by software decode)
   typedef struct packed {
      logic ae;
      logic af;
      logic empty;
      logic full;
   } fifo_stat_t;

   // packed register field positions
   localparam int WM_AE_LSB   = 16;
   localparam int WM_AF_LSB   = 0;
   localparam int WM_FIELD_W  = 9;
   localparam int PTR_RD_LSB  = 16;
   localparam int PTR_WR_LSB  = 0;
   localparam int PTR_FIELD_W = 10;
   localparam int REG_W       = 32;

endpackage

// File: rtl/afifo_wmark.sv
module afifo_wmark
   import afifo_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int TH_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [TH_W-1:0]  af_th,
   output logic [TH_W-1:0]  ae_th,
   output logic [REG_W-1:0] rdback
);

   localparam logic [TH_W-1:0] AF_RST = TH_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         af_th <= AF_RST;
         ae_th <= '0;
      end else if (we) begin
         af_th <= wdata[WM_AF_LSB +: TH_W];
         ae_th <= wdata[WM_AE_LSB +: TH_W];
      end
   end

   always_comb begin
      rdback = '0;
      rdback[WM_AF_LSB +: TH_W] = af_th;
      rdback[WM_AE_LSB +: TH_W] = ae_th;
   end

   logic wd_unused;
   assign wd_unused = ^wdata;

   AST_WM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (af_th == $past(wdata[WM_AF_LSB +: TH_W])) && (ae_th == $past(wdata[WM_AE_LSB +: TH_W]))); // R7

endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 512,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push_ok,
   input  logic              pop_ok,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [AW-1:0]     rd_ptr,
   output logic [AW-1:0]     wr_ptr
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      end
   end

   assign rdata = mem[rd_ptr];

   AST_CLR_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rd_ptr == '0) && (wr_ptr == '0)); // R9
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !push_ok) |=> $stable(wr_ptr)); // R3
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !pop_ok) |=> $stable(rd_ptr)); // R4

endmodule

// File: rtl/afifo_flags.sv
module afifo_flags
   import afifo_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int TH_W  = 9,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push_req,
   input  logic            pop_req,
   input  logic [TH_W-1:0] af_th,
   input  logic [TH_W-1:0] ae_th,
   output logic            push_ok,
   output logic            pop_ok,
   output fifo_stat_t      stat,
   output logic            ovf
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [CW-1:0] count_q;

   always_comb begin
      stat.full  = (count_q == FULL_CNT);
      stat.empty = (count_q == '0);
      stat.af    = (count_q >= CW'(af_th));
      stat.ae    = (count_q <= CW'(ae_th));
   end

   assign push_ok = push_req && !stat.full  && !clr;
   assign pop_ok  = pop_req  && !stat.empty && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count_q <= '0;
         ovf     <= 1'b0;
      end else begin
         count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
         ovf     <= push_req && stat.full;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT); // R3
   AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(stat.full) && $past(push_req)); // R3
   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> stat.empty && !ovf); // R9
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat.empty && !push_req) |=> stat.empty); // R4
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat.full && stat.empty)); // R5

endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo
   import afifo_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 512,
   parameter bit CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_clr,
   input  logic              wm_we,
   input  logic [REG_W-1:0]  wm_wdata,
   output logic [REG_W-1:0]  wm_rdata,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wr_data,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rd_data,
   input  logic              cdc_wr_en,
   input  logic [DATA_W-1:0] cdc_wr_data,
   input  logic              cdc_rd_en,
   output logic [DATA_W-1:0] cdc_rd_data,
   output logic [3:0]        fifo_stat,
   output logic              ovf_evt,
   output logic [REG_W-1:0]  ptr_word
);

   localparam int AW   = $clog2(DEPTH);
   localparam int TH_W = AW;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (AW > WM_FIELD_W || AW >= PTR_FIELD_W) begin : g_bad_width
      $error("DEPTH too large for the packed register fields");
   end
   if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data
      $error("DATA_W must be 1..32");
   end

   logic              push_req, pop_req, push_ok, pop_ok;
   logic [DATA_W-1:0] push_data, rdata;
   logic [AW-1:0]     rd_ptr, wr_ptr;
   logic [TH_W-1:0]   af_th, ae_th;
   fifo_stat_t        stat_s;

   if (CAPTURE) begin : g_capture
      assign push_req    = cdc_wr_en;
      assign push_data   = cdc_wr_data;
      assign pop_req     = bus_rd_en;
      assign bus_rd_data = rdata;
      assign cdc_rd_data = '0;
      logic side_unused;
      assign side_unused = ^{bus_wr_en, bus_wr_data, cdc_rd_en};
   end else begin : g_playback
      assign push_req    = bus_wr_en;
      assign push_data   = bus_wr_data;
      assign pop_req     = cdc_rd_en;
      assign cdc_rd_data = rdata;
      assign bus_rd_data = '0;
      logic side_unused;
      assign side_unused = ^{cdc_wr_en, cdc_wr_data, bus_rd_en};
   end

   afifo_wmark #(.DEPTH(DEPTH), .TH_W(TH_W)) u_wmark (
      .clk(clk), .rst_n(rst_n), .we(wm_we), .wdata(wm_wdata),
      .af_th(af_th), .ae_th(ae_th), .rdback(wm_rdata)
   );

   afifo_flags #(.DEPTH(DEPTH), .TH_W(TH_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .push_req(push_req), .pop_req(pop_req),
      .af_th(af_th), .ae_th(ae_th),
      .push_ok(push_ok), .pop_ok(pop_ok), .stat(stat_s), .ovf(ovf_evt)
   );

   afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .push_ok(push_ok), .pop_ok(pop_ok), .wdata(push_data),
      .rdata(rdata), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
   );

   assign fifo_stat = stat_s;

   always_comb begin
      ptr_word = '0;
      ptr_word[PTR_RD_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(rd_ptr);
      ptr_word[PTR_WR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(wr_ptr);
   end

   AST_FULL_PTRS_MEET: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_s.full || stat_s.empty) |-> (rd_ptr == wr_ptr)); // R8
   AST_PUSH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !stat_s.full && !fifo_clr) |=> !stat_s.empty); // R2

endmodule

// File: tb/sim_audio_chan_fifo.sv
`timescale 1ns/1ps
module sim_audio_chan_fifo;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        push = 0, pop = 0, clr = 0, we = 0;
   logic [31:0] wd = 0, wmd = 0;
   logic [31:0] jk = 0;

   logic [31:0] wm0, wm1, br0, br1, cr0, cr1, pw0, pw1;
   logic [3:0]  st0, st1;
   logic        ov0, ov1;

   audio_chan_fifo #(.CAPTURE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_clr(clr), .wm_we(we), .wm_wdata(wmd), .wm_rdata(wm0),
      .bus_wr_en(push), .bus_wr_data(wd), .bus_rd_en(jk[1]), .bus_rd_data(br0),
      .cdc_wr_en(jk[0]), .cdc_wr_data(jk * 3), .cdc_rd_en(pop), .cdc_rd_data(cr0),
      .fifo_stat(st0), .ovf_evt(ov0), .ptr_word(pw0));

   audio_chan_fifo #(.CAPTURE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .fifo_clr(clr), .wm_we(we), .wm_wdata(wmd), .wm_rdata(wm1),
      .bus_wr_en(jk[0]), .bus_wr_data(jk * 5), .bus_rd_en(pop), .bus_rd_data(br1),
      .cdc_wr_en(push), .cdc_wr_data(wd), .cdc_rd_en(jk[1]), .cdc_rd_data(cr1),
      .fifo_stat(st1), .ovf_evt(ov1), .ptr_word(pw1));

   int unsigned q[$];
   int rp = 0, wp = 0, af_t = 511, ae_t = 0;
   bit ovf_m = 0;
   int n_cmp = 0, n_bad = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      logic [3:0] es;
      logic [31:0] r, w, fr;
      es = {q.size() <= ae_t, q.size() >= af_t, q.size() == 0, q.size() == 512};
      chk("R5 R6 status u0", {28'b0, st0}, {28'b0, es});
      chk("R5 R6 status u1", {28'b0, st1}, {28'b0, es});
      chk("R3 overflow u0", {31'b0, ov0}, {31'b0, ovf_m});
      chk("R3 overflow u1", {31'b0, ov1}, {31'b0, ovf_m});
      chk("R4 R8 ptr u0", pw0, (rp << 16) | wp);
      chk("R4 R8 ptr u1", pw1, (rp << 16) | wp);
      chk("R7 watermark", wm0, (ae_t << 16) | af_t);
      chk("R10 idle bus data u0", br0, 0);
      chk("R10 idle codec data u1", cr1, 0);
      if (q.size() != 0) begin
         chk("R2 R10 codec data u0", cr0, q[0]);
         chk("R2 R10 bus data u1", br1, q[0]);
      end
      if (q.size() != 512) begin
         r = {22'b0, pw0[25:16]};
         w = {22'b0, pw0[9:0]};
         fr = (w >= r) ? 512 - w + r : r - w;
         chk("R8 free space", fr, 512 - q.size());
      end
   endtask

   task automatic cyc(bit pu, bit po, int unsigned d, bit c = 0, bit wre = 0, int unsigned wv = 0);
      bit full, empty;
      push = pu; pop = po; wd = d; clr = c; we = wre; wmd = wv;
      @(posedge clk);
      full = (q.size() == 512);
      empty = (q.size() == 0);
      if (c) begin
         q.delete(); rp = 0; wp = 0; ovf_m = 0;
      end else begin
         ovf_m = pu && full;
         if (po && !empty) begin void'(q.pop_front()); rp = (rp + 1) % 512; end
         if (pu && !full) begin q.push_back(d); wp = (wp + 1) % 512; end
      end
      if (wre) begin af_t = wv & 32'h1FF; ae_t = (wv >> 16) & 32'h1FF; end
      @(negedge clk);
      jk = jk + 1;
      push = 0; pop = 0; clr = 0; we = 0;
      check_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      chk("R1 reset status", {28'b0, st0}, 32'h0000000A);
      chk("R1 reset watermark", wm0, 32'h000001FF);
      chk("R1 reset pointers", pw0, 32'h0);
      check_all();

      for (int i = 0; i < 5; i++) cyc(1, 0, 100 + i);
      for (int i = 0; i < 2; i++) cyc(0, 1, 0);
      for (int i = 0; i < 4; i++) cyc(1, 1, 200 + i);
      for (int i = 0; i < 10; i++) cyc(0, 1, 0);          // R4 pops beyond empty
      cyc(1, 1, 32'h55);                                  // push+pop on empty
      cyc(0, 1, 0);

      cyc(0, 0, 0, 0, 1, (3 << 16) | 10);                 // R6 thresholds
      for (int i = 0; i < 12; i++) cyc(1, 0, 300 + i);
      for (int i = 0; i < 12; i++) cyc(0, 1, 0);
      cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF);                  // R7 reserved bits
      cyc(0, 0, 0, 0, 1, (20 << 16) | 500);

      for (int i = 0; i < 515; i++) cyc(1, 0, i ^ 32'hA5A5_0000);   // R3 fill past full
      cyc(1, 1, 32'hDEAD_BEEF);                           // R3 push dropped with pop
      cyc(1, 0, 32'h1234_5678);
      cyc(1, 0, 32'h0BAD_F00D);
      for (int i = 0; i < 520; i++) cyc(0, 1, 0);         // drain, wrap

      for (int i = 0; i < 7; i++) cyc(1, 0, 700 + i);
      cyc(1, 1, 32'hCAFE, 1);                             // R9 clear overrides
      for (int i = 0; i < 3; i++) cyc(1, 0, 800 + i);
      for (int i = 0; i < 3; i++) cyc(0, 1, 0);

      for (int i = 0; i < 512; i++) cyc(1, 0, 900 + i);
      cyc(1, 0, 32'hFEED, 1);                             // R9 clear at full, no overflow
      cyc(0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(1, 1, 1000 + i);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule